// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It takes a byte stream that carries start-of-frame and end-of-frame markers and stores each frame in memory. The memory space is a ring of descriptors. Each descriptor is two 32-bit words: a buffer address word at offset 0 and a status word at offset 4. Every buffer holds 128 bytes, so a long frame fills several consecutive descriptors. When a buffer is done, the engine writes its status word and then hands the buffer to software. It does this by rewriting the address word with the ownership bit (bit 0) set.

Software gives a buffer back by clearing that ownership bit. A descriptor whose bit 1 is set is the last one in the ring; after it, the engine goes back to the base pointer. Address-filter results arrive beside the end-of-frame byte and are stored in the final descriptor of the frame. When the engine meets a descriptor that software still owns, it discards data and raises a one-cycle overrun pulse. Clearing the receive enable stops all memory traffic and rewinds the ring.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After receive is enabled, the first descriptor read is at `ring_base`. While `dr_req` is high and `dr_valid` is low, `dr_req` stays high and `dr_addr` does not change.
- R2: Frame bytes are written little-endian from (address word with bits 1:0 cleared) + byte offset. Each write is one 32-bit word with a byte-enable bit per lane, and a partial final word leaves the bytes without an enable untouched in memory.
- R3: When a buffer closes, the engine writes the status word at descriptor+4. In the next cycle it writes descriptor+0 with the fetched address word and bit 0 set. Bit 1 (wrap) is kept as it was.
- R4: A frame longer than 128 bytes continues in the next descriptor, and every buffer except the last holds exactly 128 bytes. A frame of exactly 128 bytes uses one descriptor only.
- R5: Status bit 14 is set only in the first buffer of a frame, and bit 15 only in the last. Bits 11:0 hold the total frame length in the last buffer and are zero in every other buffer.
- R6: In the last buffer of a frame, status bit 31 is the broadcast flag, bits 26, 25, 24 and 23 are address hits 1, 2, 3 and 4 (`flt_sa_hit[0]` to `[3]`), and bit 22 is the type-ID hit. All are sampled with the end-of-frame byte. In other buffers these bits are zero.
- R7: After a descriptor whose address word has bit 1 set, the next fetch is at `ring_base`. Otherwise the next fetch is at the current descriptor + 8.
- R8: If the descriptor fetched between frames is owned by software, the engine re-reads it while no byte is offered. A frame that starts in this state is discarded with no memory writes and one `ovr_pulse`. Once software frees the descriptor, the next frame is stored in it.
- R9: If the next descriptor is owned by software in the middle of a frame, the rest of that frame is discarded and `ovr_pulse` fires once. Buffers already completed stay handed over, the owned buffer is not written, and the engine does not move past that descriptor.
- R10: While `rx_en` is low, there are no memory writes and no descriptor reads, and stream bytes are accepted and dropped. When `rx_en` is set again, fetching restarts at `ring_base`.
- R11: `s_ready` is low while a descriptor is being fetched and during write-back. Bytes offered outside a frame (before a start marker) are dropped and do not appear in any buffer.
- R12: Every memory write is word aligned and has at least one byte enable set.
- R13: `ovr_pulse` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low halts the engine and rewinds the ring |
| ring_base | input | 32 | Address of the first descriptor (8-byte aligned) |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| flt_bcast | input | 1 | Broadcast destination, valid with the end byte |
| flt_sa_hit | input | 4 | Specific-address hits 1..4 (bit 0 = address 1), valid with the end byte |
| flt_type_hit | input | 1 | Type-ID hit, valid with the end byte |
| dr_req | output | 1 | Descriptor address-word read request |
| dr_addr | output | 32 | Address of the word to read |
| dr_valid | input | 1 | Read data returned |
| dr_data | input | 32 | Address word of the descriptor |
| mw_en | output | 1 | Memory write strobe |
| mw_addr | output | 32 | Word-aligned write address |
| mw_data | output | 32 | Write data |
| mw_be | output | 4 | Byte enables, bit n covers bits 8n+7:8n |
| ovr_pulse | output | 1 | One-cycle pulse when data is lost for lack of a buffer |

## Verification
The hardest state to reach is a descriptor that software still owns, found in the middle of a frame. The engine fetches each descriptor as soon as the previous one closes, so the ownership bit must already be set when the preceding buffer finishes. The bench therefore leaves the descriptor after the ring's wrap entry owned from an earlier frame. It then sends a 200-byte frame into the wrap descriptor, so the fetch that follows the first 128 bytes lands on that owned entry. A second run makes the descriptor owned before the previous frame ends, which covers the case of a descriptor found owned between frames. That run also checks that the engine keeps re-reading until the entry is freed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;

  // address word flags
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;

  // status word layout
  localparam int ST_LEN_W  = 12;
  localparam int ST_FIRST  = 14;
  localparam int ST_LAST   = 15;
  localparam int ST_TYPE   = 22;
  localparam int ST_SA_LO  = 23;  // hit 4 here, hit 1 at ST_SA_LO+3
  localparam int ST_BCAST  = 31;

  typedef enum logic [2:0] {
    S_OFF, S_FETCH, S_NOBUF, S_READY, S_FILL, S_WB_STAT, S_WB_ADDR, S_DROP
  } rxr_state_e;

  typedef struct packed {
    logic       bcast;
    logic [3:0] sa;
    logic       typ;
  } rxr_hits_t;
endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          take,
  input  logic                          flush,
  input  logic [$clog2(LANES)-1:0]      lane,
  input  logic [7:0]                    din,
  output logic [8*LANES-1:0]            word_o,
  output logic [LANES-1:0]              be_o
);
  localparam int LANE_W = $clog2(LANES);

  logic [8*LANES-1:0] acc;
  logic [LANES-1:0]   acc_be;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit              = take && (lane == LANE_W'(g));
    assign word_o[8*g +: 8] = hit ? din : acc[8*g +: 8];
    assign be_o[g]          = hit | acc_be[g];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc    <= '0;
      acc_be <= '0;
    end else if (take) begin
      acc <= word_o;
      if (flush) acc_be <= '0;
      else       acc_be <= be_o;
    end
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (rst || load)  ptr <= base;
    else if (adv)     ptr <= wrap ? base : ptr + STEP;
  end
endmodule

// File: rtl/rxr_status_build.sv
module rxr_status_build
  import rxr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              first,
  input  logic              last,
  input  logic [LEN_W-1:0]  len,
  input  rxr_hits_t         hits,
  output logic [WORD_W-1:0] st
);
  always_comb begin
    st           = '0;
    st[ST_FIRST] = first;
    st[ST_LAST]  = last;
    if (last) begin
      st[ST_LEN_W-1:0] = ST_LEN_W'(len);
      st[ST_BCAST]     = hits.bcast;
      st[ST_TYPE]      = hits.typ;
      for (int i = 0; i < 4; i++) begin
        st[ST_SA_LO + 3 - i] = hits.sa[i];
      end
    end
  end
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_sof,
  input  logic        s_eof,
  input  logic        flt_bcast,
  input  logic [3:0]  flt_sa_hit,
  input  logic        flt_type_hit,
  output logic        dr_req,
  output logic [31:0] dr_addr,
  input  logic        dr_valid,
  input  logic [31:0] dr_data,
  output logic        mw_en,
  output logic [31:0] mw_addr,
  output logic [31:0] mw_data,
  output logic [3:0]  mw_be,
  output logic        ovr_pulse
);
  localparam int OFF_W  = $clog2(BUF_BYTES);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);
  localparam logic [31:0] STAT_STEP = 32'(STAT_OFS);

  rxr_state_e        state;
  logic [31:0]       desc_word;
  logic [31:0]       ptr;
  logic [31:0]       buf_base;
  logic [31:0]       st_word;
  logic [31:0]       pk_word;
  logic [LANES-1:0]  pk_be;
  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  flen;
  logic              in_frame;
  logic              first_buf;
  logic              last_buf;
  rxr_hits_t         hits;
  logic              take;
  logic              flush;
  logic              buf_full;
  logic              adv;
  logic [31:0]       word_ofs;

  assign buf_base = {desc_word[31:2], 2'b00};
  assign word_ofs = {{(32-OFF_W){1'b0}}, off[OFF_W-1:LANE_W], {LANE_W{1'b0}}};
  assign s_ready  = !rx_en || (state inside {S_OFF, S_NOBUF, S_READY, S_FILL, S_DROP});
  assign take     = rx_en && s_valid &&
                    ((state == S_FILL) || ((state == S_READY) && s_sof));
  assign buf_full = (off == OFF_LAST);
  assign flush    = take && ((off[LANE_W-1:0] == {LANE_W{1'b1}}) || s_eof);
  assign adv      = rx_en && (state == S_WB_ADDR);
  assign dr_req   = rx_en && (state == S_FETCH);
  assign dr_addr  = ptr;

  rxr_ring_ptr #(.ADDR_W(32), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .load (!rx_en),
    .base (ring_base),
    .adv  (adv),
    .wrap (desc_word[WRAP_BIT]),
    .ptr  (ptr)
  );

  rxr_byte_packer #(.LANES(LANES)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clr    (!rx_en),
    .take   (take),
    .flush  (flush),
    .lane   (off[LANE_W-1:0]),
    .din    (s_data),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rxr_status_build #(.LEN_W(LEN_W)) u_stat (
    .first (first_buf),
    .last  (last_buf),
    .len   (flen),
    .hits  (hits),
    .st    (st_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_OFF;
      desc_word <= '0;
      off       <= '0;
      flen      <= '0;
      in_frame  <= 1'b0;
      first_buf <= 1'b0;
      last_buf  <= 1'b0;
      hits      <= '0;
      mw_en     <= 1'b0;
      mw_addr   <= '0;
      mw_data   <= '0;
      mw_be     <= '0;
      ovr_pulse <= 1'b0;
    end else begin
      mw_en     <= 1'b0;
      ovr_pulse <= 1'b0;
      if (!rx_en) begin
        state     <= S_OFF;
        in_frame  <= 1'b0;
        first_buf <= 1'b0;
      end else begin
        case (state)
          S_OFF: state <= S_FETCH;

          S_FETCH: begin
            if (dr_valid) begin
              desc_word <= dr_data;
              off       <= '0;
              if (dr_data[OWN_BIT]) begin
                if (in_frame) begin
                  ovr_pulse <= 1'b1;
                  in_frame  <= 1'b0;
                  state     <= S_DROP;
                end else begin
                  state <= S_NOBUF;
                end
              end else begin
                state <= in_frame ? S_FILL : S_READY;
              end
            end
          end

          S_NOBUF: begin
            if (s_valid && s_sof) begin
              ovr_pulse <= 1'b1;
              state     <= s_eof ? S_FETCH : S_DROP;
            end else if (!s_valid) begin
              state <= S_FETCH;
            end
          end

          S_DROP: begin
            if (s_valid && s_eof) state <= S_FETCH;
          end

          S_READY, S_FILL: begin
            if (take) begin
              off      <= off + 1'b1;
              in_frame <= 1'b1;
              if (state == S_READY) begin
                flen      <= LEN_W'(1);
                first_buf <= 1'b1;
              end else begin
                flen <= flen + 1'b1;
              end
              if (flush) begin
                mw_en   <= 1'b1;
                mw_addr <= buf_base + word_ofs;
                mw_data <= pk_word;
                mw_be   <= pk_be;
              end
              if (s_eof) begin
                last_buf <= 1'b1;
                hits     <= '{bcast: flt_bcast, sa: flt_sa_hit, typ: flt_type_hit};
                state    <= S_WB_STAT;
              end else if (buf_full) begin
                last_buf <= 1'b0;
                state    <= S_WB_STAT;
              end else begin
                state <= S_FILL;
              end
            end
          end

          S_WB_STAT: begin
            mw_en   <= 1'b1;
            mw_addr <= ptr + STAT_STEP;
            mw_data <= st_word;
            mw_be   <= '1;
            state   <= S_WB_ADDR;
          end

          S_WB_ADDR: begin
            mw_en     <= 1'b1;
            mw_addr   <= ptr;
            mw_data   <= desc_word | 32'(1 << OWN_BIT);
            mw_be     <= '1;
            first_buf <= 1'b0;
            if (last_buf) in_frame <= 1'b0;
            state     <= S_FETCH;
          end

          default: state <= S_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_desc_ring_writer_chk.sv
module rx_desc_ring_writer_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_en,
  input logic        s_ready,
  input logic        dr_req,
  input logic        dr_valid,
  input logic [31:0] dr_addr,
  input logic        mw_en,
  input logic [31:0] mw_addr,
  input logic [3:0]  mw_be,
  input logic        ovr_pulse
);
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dr_req && !dr_valid) ##1 rx_en |-> dr_req && $stable(dr_addr)); // R1

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mw_en |-> (mw_addr[1:0] == 2'b00) && (mw_be != 4'b0000)); // R12

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !mw_en && !ovr_pulse); // R10

  AST_STALL_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
    dr_req |-> !s_ready); // R11

  AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovr_pulse |=> !ovr_pulse); // R13
endmodule

bind rx_desc_ring_writer rx_desc_ring_writer_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .s_ready   (s_ready),
  .dr_req    (dr_req),
  .dr_valid  (dr_valid),
  .dr_addr   (dr_addr),
  .mw_en     (mw_en),
  .mw_addr   (mw_addr),
  .mw_be     (mw_be),
  .ovr_pulse (ovr_pulse)
);

// File: tb/rx_desc_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_desc_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        rx_en;
  logic [31:0] ring_base;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_data;
  logic        s_sof;
  logic        s_eof;
  logic        flt_bcast;
  logic [3:0]  flt_sa_hit;
  logic        flt_type_hit;
  logic        dr_req;
  logic [31:0] dr_addr;
  logic        dr_valid;
  logic [31:0] dr_data;
  logic        mw_en;
  logic [31:0] mw_addr;
  logic [31:0] mw_data;
  logic [3:0]  mw_be;
  logic        ovr_pulse;

  always #5 clk = ~clk;

  rx_desc_ring_writer dut_i (
    .clk (clk), .rst (rst), .rx_en (rx_en), .ring_base (ring_base),
    .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data),
    .s_sof (s_sof), .s_eof (s_eof), .flt_bcast (flt_bcast),
    .flt_sa_hit (flt_sa_hit), .flt_type_hit (flt_type_hit),
    .dr_req (dr_req), .dr_addr (dr_addr), .dr_valid (dr_valid),
    .dr_data (dr_data), .mw_en (mw_en), .mw_addr (mw_addr),
    .mw_data (mw_data), .mw_be (mw_be), .ovr_pulse (ovr_pulse)
  );

  localparam logic [31:0] D0 = 32'h100, D1 = 32'h108, D2 = 32'h110, D3 = 32'h118;

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, misalign = 0, ovr_cnt = 0, off_act = 0, stall_err = 0;
  logic [31:0] last_fetch = '0;
  bit done = 1'b0;

  // descriptor read responder, one cycle latency
  initial begin
    dr_valid = 1'b0;
    dr_data  = '0;
    forever begin
      @(posedge clk); #1;
      if (dr_req && !dr_valid) begin
        dr_valid = 1'b1;
        dr_data  = mem[dr_addr[11:2]];
      end else begin
        dr_valid = 1'b0;
      end
    end
  end

  // memory write port and observation counters
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst) begin
        if (mw_en) begin
          wr_cnt++;
          if (mw_addr[1:0] != 2'b00) misalign++;
          for (int b = 0; b < 4; b++)
            if (mw_be[b]) mem[mw_addr[11:2]][8*b +: 8] = mw_data[8*b +: 8];
        end
        if (ovr_pulse) ovr_cnt++;
        if (dr_req) last_fetch = dr_addr;
        if (dr_req && s_ready) stall_err++;
        if (!rx_en && (mw_en || dr_req)) off_act++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic chk_buf(input string tag, input logic [31:0] a, input int n, input int seed);
    int errs = 0;
    for (int i = 0; i < n; i++)
      if (rd_byte(a + 32'(i)) !== 8'((seed + i) & 255)) errs++;
    chk(tag, 32'(errs), 32'd0);
  endtask

  task automatic put_byte(input logic [7:0] d, input logic sof, input logic eof);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int seed, input logic bc,
                            input logic [3:0] sa, input logic ty);
    flt_bcast = bc; flt_sa_hit = sa; flt_type_hit = ty;
    for (int i = 0; i < len; i++)
      put_byte(8'((seed + i) & 255), i == 0, i == len - 1);
    settle();
    flt_bcast = 1'b0; flt_sa_hit = '0; flt_type_hit = 1'b0;
  endtask

  task automatic reclaim_all();
    mem[D0 >> 2] = 32'h400;
    mem[D1 >> 2] = 32'h480;
    mem[D2 >> 2] = 32'h500;
    mem[D3 >> 2] = 32'h582;
  endtask

  task automatic t_reset();
    chk("R10 reset mw_en", {31'b0, mw_en}, 32'd0);
    chk("R10 reset dr_req", {31'b0, dr_req}, 32'd0);
    chk("R13 reset ovr_pulse", {31'b0, ovr_pulse}, 32'd0);
    @(negedge clk); rx_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 first fetch at ring_base", last_fetch, D0);
  endtask

  task automatic t_short_frame();
    send_frame(10, 8'h10, 1'b1, 4'b0000, 1'b1);
    chk_buf("R2 short frame data", 32'h400, 10, 8'h10);
    chk("R2 partial word keeps unenabled bytes", mem[32'h408 >> 2], 32'hDEAD1918);
    chk("R2 next word untouched", mem[32'h40C >> 2], 32'hDEADBEEF);
    chk("R5 R6 single buffer status", mem[(D0 + 4) >> 2], 32'h8040C00A);
    chk("R3 ownership set", mem[D0 >> 2], 32'h401);
  endtask

  task automatic t_long_frame();
    send_frame(300, 8'h40, 1'b0, 4'b0101, 1'b0);
    chk_buf("R4 first buffer data", 32'h480, 128, 8'h40);
    chk_buf("R4 second buffer data", 32'h500, 128, 8'h40 + 128);
    chk_buf("R4 third buffer data", 32'h580, 44, 8'h40 + 256);
    chk("R5 first buffer status", mem[(D1 + 4) >> 2], 32'h00004000);
    chk("R5 middle buffer status", mem[(D2 + 4) >> 2], 32'h00000000);
    chk("R6 last buffer status", mem[(D3 + 4) >> 2], 32'h0500812C);
    chk("R3 wrap bit kept with ownership", mem[D3 >> 2], 32'h583);
    chk("R7 fetch after wrap descriptor", last_fetch, D0);
  endtask

  task automatic t_word_frame();
    reclaim_all();
    repeat (6) @(negedge clk);
    send_frame(4, 8'h30, 1'b0, 4'b0000, 1'b0);
    chk("R2 full word frame", mem[32'h400 >> 2], 32'h33323130);
    chk("R5 four byte status", mem[(D0 + 4) >> 2], 32'h0000C004);
  endtask

  task automatic t_exact_buffer();
    mem[D2 >> 2] = 32'h501;  // owned before the frame ends
    send_frame(128, 8'h50, 1'b0, 4'b0000, 1'b0);
    chk_buf("R4 exact buffer data", 32'h480, 128, 8'h50);
    chk("R4 exact buffer status", mem[(D1 + 4) >> 2], 32'h0000C080);
    chk("R4 exact buffer owned", mem[D1 >> 2], 32'h481);
    chk("R4 next descriptor untouched", mem[(D2 + 4) >> 2], 32'h00000000);
    chk("R8 no overrun while idle", 32'(ovr_cnt), 32'd0);
  endtask

  task automatic t_owned_at_start();
    logic [31:0] snap;
    int w0, o0;
    snap = mem[32'h500 >> 2];
    w0 = wr_cnt; o0 = ovr_cnt;
    send_frame(20, 8'h60, 1'b0, 4'b0000, 1'b0);
    chk("R8 dropped frame makes no writes", 32'(wr_cnt - w0), 32'd0);
    chk("R8 one overrun pulse", 32'(ovr_cnt - o0), 32'd1);
    chk("R8 owned buffer untouched", mem[32'h500 >> 2], snap);
    mem[D2 >> 2] = 32'h500;
    repeat (6) @(negedge clk);
    send_frame(9, 8'h70, 1'b0, 4'b0010, 1'b0);
    chk_buf("R8 freed descriptor receives", 32'h500, 9, 8'h70);
    chk("R6 address 2 hit status", mem[(D2 + 4) >> 2], 32'h0200C009);
    chk("R8 freed descriptor owned", mem[D2 >> 2], 32'h501);
  endtask

  task automatic t_owned_mid_frame();
    int o0;
    o0 = ovr_cnt;
    send_frame(200, 8'h90, 1'b0, 4'b0000, 1'b0);
    chk_buf("R9 completed buffer kept", 32'h580, 128, 8'h90);
    chk("R9 completed buffer status", mem[(D3 + 4) >> 2], 32'h00004000);
    chk("R9 completed buffer owned", mem[D3 >> 2], 32'h583);
    chk("R9 one overrun pulse", 32'(ovr_cnt - o0), 32'd1);
    chk("R9 owned buffer unwritten", mem[32'h400 >> 2], 32'h33323130);
    chk("R9 owned descriptor unchanged", mem[D0 >> 2], 32'h401);
    mem[D0 >> 2] = 32'h400;
    repeat (6) @(negedge clk);
    send_frame(6, 8'hA0, 1'b0, 4'b0000, 1'b0);
    chk_buf("R9 no skip past owned entry", 32'h400, 6, 8'hA0);
    chk("R9 resumed status", mem[(D0 + 4) >> 2], 32'h0000C006);
  endtask

  task automatic t_disable();
    int w0;
    @(negedge clk); rx_en = 1'b0;
    reclaim_all();
    w0 = wr_cnt;
    @(negedge clk);
    chk("R10 ready while disabled", {31'b0, s_ready}, 32'd1);
    send_frame(8, 8'hB0, 1'b0, 4'b0000, 1'b0);
    chk("R10 no writes while disabled", 32'(wr_cnt - w0), 32'd0);
    chk("R10 no activity while disabled", 32'(off_act), 32'd0);
    @(negedge clk); rx_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 restart at ring_base", last_fetch, D0);
  endtask

  task automatic t_stray_bytes();
    for (int i = 0; i < 3; i++) put_byte(8'hEE, 1'b0, 1'b0);
    settle();
    send_frame(5, 8'hC0, 1'b0, 4'b0000, 1'b0);
    chk_buf("R11 stray bytes dropped", 32'h400, 5, 8'hC0);
    chk("R11 frame status", mem[(D0 + 4) >> 2], 32'h0000C005);
    chk("R11 ready low during fetch", 32'(stall_err), 32'd0);
    chk("R12 writes aligned", 32'(misalign), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
    reclaim_all();
    for (int k = 0; k < 4; k++) mem[(D0 >> 2) + 2 * k + 1] = 32'hFFFFFFFF;
    rst = 1'b1; rx_en = 1'b0; ring_base = D0;
    s_valid = 1'b0; s_data = '0; s_sof = 1'b0; s_eof = 1'b0;
    flt_bcast = 1'b0; flt_sa_hit = '0; flt_type_hit = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short_frame();
    t_long_frame();
    t_word_frame();
    t_exact_buffer();
    t_owned_at_start();
    t_owned_mid_frame();
    t_disable();
    t_stray_bytes();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule